// File: doc/BRIEF.md
# Self-Timed Program and Erase Sequencer

This block runs the non-volatile update cycle of a small serial memory once its serial front end has decoded a complete modifying command. The front end hands over an opcode, an address and a data word with a one-cycle valid pulse. The sequencer keeps that command pending until the chip-select line falls. It then runs on its own system clock and needs no serial clock at all. A busy flag covers the whole cycle, so the front end can report ready or busy while the host polls.

Each cycle has two timed phases. The clear phase drives the targeted bytes to all ones. The store phase then writes the new data. Erase commands use only the clear phase. A write therefore needs no erase beforehand. The global commands act on every byte of the array within the same timed cycle. The array is held as bytes. The organisation input selects between byte mode and 16-bit word mode. A combinational read port lets the front end read the array for its read commands.

Top module: `pe_sequencer`

## Requirements
- R1: After reset, busy_o is low and every byte of the array reads 0xFF.
- R2: The opcode on req_op_i is encoded as 0 = write one location, 1 = erase one location, 2 = erase all, 3 = write all. A cycle starts only when a request is pending and cs_i is sampled low one clock after it was sampled high; busy_o is high from that clock edge on. A request alone, or a chip-select fall with nothing pending, starts nothing.
- R3: busy_o stays high for exactly CLR_CYC + PRG_CYC clock cycles for both write commands, and for exactly CLR_CYC cycles for both erase commands. It then falls.
- R4: For both write commands, the targeted bytes read all ones from the end of the clear phase until the end of the store phase. At the end of the store phase they take the new data.
- R5: In byte mode (wide_i = 0), a write to address A changes only byte A and stores req_data_i[7:0]. req_data_i[15:8] is ignored.
- R6: In word mode (wide_i = 1), address A selects word W = A[ADDR_W-2:0]. Byte 2W receives req_data_i[15:8] and byte 2W+1 receives req_data_i[7:0]. The top address bit is ignored.
- R7: An erase of one location sets the byte (or the two bytes of the word) to 0xFF and leaves every other byte unchanged.
- R8: Erase-all sets every byte to 0xFF in one cycle, whatever the address.
- R9: Write-all stores req_data_i[7:0] in every byte in byte mode. In word mode it stores the word pattern in every word, with the same byte order as R6.
- R10: A request that arrives while busy_o is high is dropped. It does not lengthen the running cycle and does not start a cycle at a later chip-select fall.
- R11: In byte mode rd_data_o is {8'h00, byte[rd_addr_i]}. In word mode it is {byte[2W], byte[2W+1]} with W = rd_addr_i[ADDR_W-2:0].
- R12: The array changes only at the end of a phase. While idle the read port holds its value for a steady address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that times the phases |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip-select level; a falling edge launches the pending command |
| req_valid_i | input | 1 | One-cycle pulse: a complete command is available |
| req_op_i | input | 2 | Command opcode (R2 encoding) |
| req_addr_i | input | ADDR_W | Byte address, or word address in its low ADDR_W-1 bits |
| req_data_i | input | 16 | Write data |
| wide_i | input | 1 | Organisation: 1 = 16-bit words, 0 = bytes |
| rd_addr_i | input | ADDR_W | Read address |
| busy_o | output | 1 | High for the whole self-timed cycle |
| rd_data_o | output | 16 | Read data (R11 layout) |

## Verification
The bench uses a 64-byte array with phase lengths of 4 and 6 cycles. Writes are tried at the lowest address, the highest address and an inner address, in both organisations. Data with a non-zero upper byte checks that byte mode ignores it, and an address with the top bit set checks that word mode ignores that bit. After every command, both organisations of the read port are swept over the whole array and compared with an arithmetic model. This separates errors in byte order, word decoding and single versus global targeting. The bench also times the busy window and samples the target at the end of the clear phase. It tries a request held without a chip-select fall, a chip-select fall with nothing pending, and a request injected mid-cycle. These show that launching depends only on the chip-select edge and that late requests are dropped.

// File: rtl/pe_seq_pkg.sv
`timescale 1ns/1ps
package pe_seq_pkg;
  typedef enum logic [1:0] {
    OP_WRITE     = 2'd0,
    OP_ERASE     = 2'd1,
    OP_ERASE_ALL = 2'd2,
    OP_WRITE_ALL = 2'd3
  } pe_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_STORE = 2'd2
  } pe_state_e;
endpackage

// File: rtl/pe_phase_timer.sv
`timescale 1ns/1ps
module pe_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expire_o = run_i && (cnt_q == lim_i - CNT_W'(1));
endmodule

// File: rtl/pe_ctrl.sv
`timescale 1ns/1ps
module pe_ctrl
  import pe_seq_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int CLR_CYC = 4,
  parameter int PRG_CYC = 6,
  parameter int CNT_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [15:0]       req_data_i,
  input  logic              wide_i,
  input  logic              expire_i,
  output logic              tmr_clr_o,
  output logic              tmr_run_o,
  output logic [CNT_W-1:0]  lim_o,
  output logic              clear_o,
  output logic              store_o,
  output logic              all_o,
  output logic              wide_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       data_o,
  output logic              busy_o
);
  pe_state_e         state_q, state_d;
  pe_op_e            op_q;
  logic              cs_q, pend_q;
  logic              idle, cs_fall, start, accept, erase_only;

  assign idle       = (state_q == ST_IDLE);
  assign cs_fall    = cs_q && !cs_i;
  assign start      = idle && pend_q && cs_fall;
  assign accept     = idle && req_valid_i && !start;
  assign erase_only = (op_q == OP_ERASE) || (op_q == OP_ERASE_ALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= 1'b0;
      pend_q <= 1'b0;
      op_q   <= OP_WRITE;
      wide_o <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      cs_q <= cs_i;
      if (start)       pend_q <= 1'b0;
      else if (accept) pend_q <= 1'b1;
      if (accept) begin
        op_q   <= pe_op_e'(req_op_i);
        wide_o <= wide_i;
        addr_o <= req_addr_i;
        data_o <= req_data_i;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start) state_d = ST_CLEAR;
      ST_CLEAR: if (expire_i) state_d = erase_only ? ST_IDLE : ST_STORE;
      ST_STORE: if (expire_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign clear_o   = (state_q == ST_CLEAR) && expire_i;
  assign store_o   = (state_q == ST_STORE) && expire_i;
  assign tmr_clr_o = start || clear_o;
  assign tmr_run_o = !idle;
  assign lim_o     = (state_q == ST_STORE) ? CNT_W'(PRG_CYC) : CNT_W'(CLR_CYC);
  assign all_o     = (op_q == OP_ERASE_ALL) || (op_q == OP_WRITE_ALL);
  assign busy_o    = !idle;
endmodule

// File: rtl/pe_byte_array.sv
`timescale 1ns/1ps
module pe_byte_array #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              store_i,
  input  logic              all_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       data_i,
  input  logic              rd_wide_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [15:0]       rd_data_o
);
  localparam int NBYTES = 1 << ADDR_W;

  logic [NBYTES*8-1:0] flat;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    logic       hit;
    logic [7:0] wval;
    logic [7:0] byte_q;

    assign hit  = all_i ||
                  (wide_i ? (addr_i[ADDR_W-2:0] == IDX[ADDR_W-1:1]) : (addr_i == IDX));
    assign wval = (wide_i && !IDX[0]) ? data_i[15:8] : data_i[7:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                byte_q <= 8'hFF;
      else if (hit && clear_i)    byte_q <= 8'hFF;
      else if (hit && store_i)    byte_q <= wval;
    end

    assign flat[i*8 +: 8] = byte_q;
  end

  logic [ADDR_W-1:0] hi_idx, lo_idx;
  assign hi_idx = {rd_addr_i[ADDR_W-2:0], 1'b0};
  assign lo_idx = {rd_addr_i[ADDR_W-2:0], 1'b1};

  always_comb begin
    if (rd_wide_i) rd_data_o = {flat[{hi_idx, 3'b000} +: 8], flat[{lo_idx, 3'b000} +: 8]};
    else           rd_data_o = {8'h00, flat[{rd_addr_i, 3'b000} +: 8]};
  end
endmodule

// File: rtl/pe_sequencer.sv
`timescale 1ns/1ps
module pe_sequencer #(
  parameter int ADDR_W  = 11,
  parameter int CLR_CYC = 200000,
  parameter int PRG_CYC = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [15:0]       req_data_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              busy_o,
  output logic [15:0]       rd_data_o
);
  localparam int MAX_CYC = (CLR_CYC > PRG_CYC) ? CLR_CYC : PRG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic              tmr_clr, tmr_run, expire;
  logic [CNT_W-1:0]  lim;
  logic              clear, store, all, cmd_wide;
  logic [ADDR_W-1:0] cmd_addr;
  logic [15:0]       cmd_data;

  pe_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .run_i    (tmr_run),
    .lim_i    (lim),
    .expire_o (expire)
  );

  pe_ctrl #(
    .ADDR_W (ADDR_W), .CLR_CYC(CLR_CYC), .PRG_CYC(PRG_CYC), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_i),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_addr_i  (req_addr_i),
    .req_data_i  (req_data_i),
    .wide_i      (wide_i),
    .expire_i    (expire),
    .tmr_clr_o   (tmr_clr),
    .tmr_run_o   (tmr_run),
    .lim_o       (lim),
    .clear_o     (clear),
    .store_o     (store),
    .all_o       (all),
    .wide_o      (cmd_wide),
    .addr_o      (cmd_addr),
    .data_o      (cmd_data),
    .busy_o      (busy_o)
  );

  pe_byte_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .store_i   (store),
    .all_i     (all),
    .wide_i    (cmd_wide),
    .addr_i    (cmd_addr),
    .data_i    (cmd_data),
    .rd_wide_i (wide_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/pe_sequencer_chk.sv
`timescale 1ns/1ps
module pe_sequencer_chk #(
  parameter int ADDR_W  = 11,
  parameter int CLR_CYC = 200000,
  parameter int PRG_CYC = 250000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              wide_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              busy_o,
  input logic [15:0]       rd_data_o
);
  localparam int TOTAL = CLR_CYC + PRG_CYC;
  localparam int CW    = $clog2(TOTAL + 1);

  logic [CW-1:0] bcnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt <= '0;
    else if (busy_o) bcnt <= bcnt + CW'(1);
    else             bcnt <= '0;
  end

  assert_busy_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bcnt < CW'(TOTAL)));

  assert_min_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(bcnt) >= CW'(CLR_CYC - 1)));

  assert_launch_cs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> (!$past(cs_i) && $past(cs_i, 2)));

  assert_idle_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && $stable(rd_addr_i) && $stable(wide_i)) |-> $stable(rd_data_o));
endmodule

bind pe_sequencer pe_sequencer_chk #(
  .ADDR_W(ADDR_W), .CLR_CYC(CLR_CYC), .PRG_CYC(PRG_CYC)
) u_chk (.*);

// File: tb/pe_sequencer_bench.sv
`timescale 1ns/1ps
module pe_sequencer_bench;
  localparam int AW  = 6;
  localparam int NB  = 64;
  localparam int CLR = 4;
  localparam int PRG = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cs = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0]   req_data = '0;
  logic          wide = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          busy;
  logic [15:0]   rd_data;

  logic [7:0] exp_mem [NB];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pe_sequencer #(.ADDR_W(AW), .CLR_CYC(CLR), .PRG_CYC(PRG)) u_pe_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .req_valid_i(req_valid),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
    .wide_i(wide), .rd_addr_i(rd_addr), .busy_o(busy), .rd_data_o(rd_data)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model(logic [1:0] op, logic [AW-1:0] a, logic [15:0] d, logic w);
    for (int i = 0; i < NB; i++) begin
      bit hit;
      logic [7:0] v;
      hit = (op >= 2) ? 1'b1 : (w ? ((i >> 1) == (a % 32)) : (i == a));
      if (op == 2'd1 || op == 2'd2) v = 8'hFF;
      else v = (w && (i % 2 == 0)) ? d[15:8] : d[7:0];
      if (hit) exp_mem[i] = v;
    end
  endtask

  task automatic sweep(string tag);
    int bad = 0;
    logic [15:0] fa = '0, fe = '0;
    for (int i = 0; i < NB; i++) begin
      wide = 1'b0; rd_addr = AW'(i); #1;
      if (rd_data !== {8'h00, exp_mem[i]}) begin
        if (bad == 0) begin fa = rd_data; fe = {8'h00, exp_mem[i]}; end
        bad++;
      end
    end
    for (int wi = 0; wi < NB/2; wi++) begin
      wide = 1'b1; rd_addr = AW'(wi); #1;
      if (rd_data !== {exp_mem[2*wi], exp_mem[2*wi+1]}) begin
        if (bad == 0) begin fa = rd_data; fe = {exp_mem[2*wi], exp_mem[2*wi+1]}; end
        bad++;
      end
    end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s R11 sweep: actual %0h expected %0h (%0d mismatches)", tag, fa, fe, bad);
    end
  endtask

  task automatic run_op(logic [1:0] op, logic [AW-1:0] a, logic [15:0] d, logic w,
                        int hold, string tag);
    int n;
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; wide = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    rd_addr = w ? AW'(a % 32) : a;
    for (int h = 0; h < hold; h++) @(negedge clk);
    if (hold > 0) chk({tag, " R2 pending without cs fall"}, 32'(busy), 32'd0);
    cs = 1'b0;
    @(negedge clk);
    chk({tag, " R2 busy on cs fall"}, 32'(busy), 32'd1);
    n = 1;
    while (busy && n < 100) begin
      if (n == CLR + 1 && (op == 2'd0 || op == 2'd3))
        chk({tag, " R4 cleared before store"}, 32'(rd_data), w ? 32'hFFFF : 32'h00FF);
      @(negedge clk);
      n++;
    end
    chk({tag, " R3 busy length"}, 32'(n - 1),
        (op == 2'd0 || op == 2'd3) ? 32'(CLR + PRG) : 32'(CLR));
    model(op, a, d, w);
    cs = 1'b1;
    @(negedge clk);
    sweep(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", 32'(busy), 32'd0);
    sweep("R1 reset contents");

    run_op(2'd0, 6'd0,  16'h00A5, 1'b0, 0, "R5 write x8 low");
    run_op(2'd0, 6'd63, 16'h1200, 1'b0, 0, "R5 write x8 high");
    run_op(2'd0, 6'd21, 16'hAB5C, 1'b0, 0, "R5 upper byte ignored");
    run_op(2'd0, 6'd42, 16'hA55A, 1'b1, 0, "R6 write x16 top bit");
    run_op(2'd0, 6'd31, 16'h0F0F, 1'b1, 0, "R6 write x16 last word");
    run_op(2'd1, 6'd63, 16'h0000, 1'b0, 0, "R7 erase x8");
    run_op(2'd1, 6'd10, 16'h0000, 1'b1, 0, "R7 erase x16");

    // cs fall with nothing pending
    @(negedge clk); cs = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R2 no pending no start", 32'(busy), 32'd0);
    cs = 1'b1;
    @(negedge clk);

    run_op(2'd0, 6'd5, 16'h0077, 1'b0, 5, "R2 held request");

    // request injected mid-cycle is dropped
    begin
      int n;
      @(negedge clk);
      req_op = 2'd0; req_addr = 6'd30; req_data = 16'h0011; wide = 1'b0; req_valid = 1'b1;
      @(negedge clk); req_valid = 1'b0; rd_addr = 6'd30;
      cs = 1'b0;
      @(negedge clk);
      chk("R10 busy on launch", 32'(busy), 32'd1);
      n = 1;
      while (busy && n < 100) begin
        if (n == 3) begin req_addr = 6'd50; req_data = 16'h00EE; req_valid = 1'b1; end
        if (n == 4) req_valid = 1'b0;
        @(negedge clk);
        n++;
      end
      chk("R10 timer not restarted", 32'(n - 1), 32'(CLR + PRG));
      model(2'd0, 6'd30, 16'h0011, 1'b0);
      cs = 1'b1;
      @(negedge clk); @(negedge clk);
      cs = 1'b0;
      @(negedge clk); @(negedge clk);
      chk("R10 dropped request never launches", 32'(busy), 32'd0);
      cs = 1'b1;
      @(negedge clk);
      sweep("R10 array after drop");
    end

    run_op(2'd3, 6'd17, 16'hFF3C, 1'b0, 0, "R9 write-all x8");
    run_op(2'd1, 6'd7,  16'h0000, 1'b0, 0, "R7 erase after write-all");
    run_op(2'd3, 6'd0,  16'h1234, 1'b1, 0, "R9 write-all x16");
    run_op(2'd0, 6'd9,  16'h005A, 1'b0, 0, "R4 write over data");
    run_op(2'd2, 6'd33, 16'h0000, 1'b1, 0, "R8 erase-all");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule